// File: doc/BRIEF.md
# Paged Data Address Generator

This block keeps the pointer registers used to reach data memory: three byte-wide counters (an index X, a backup/limit Y and a page Z) and a 16-bit link register L. Every cycle it forms a 14-bit data address from the current contents. The low seven bits come from X. The upper seven bits come from Z, but only when the top bit of X is set. When that bit is clear, the address falls in page zero. This short form lets a single byte reach a base page.

Each access strobe carries a mode. The mode chooses what happens to the registers after the access. X can be left alone, stepped up or down, stepped and then exchanged with L as a complete page:byte pair, or stepped and then exchanged with Y. X can also be stepped and compared with Y as a loop bound. Two further modes exchange X with Y, or copy the Z:X pair into L. A load port writes any single register directly. The register contents are visible on output ports. A registered done flag reports a zero crossing or a match with Y after the stepping modes.

Top module: `paged_addr_gen`

## Requirements
- R1: When x_o[7] is 1, addr_o equals {z_o[6:0], x_o[6:0]}, combinationally from the current register values.
- R2: When x_o[7] is 0, addr_o[13:7] is zero and addr_o[6:0] equals x_o[6:0], whatever Z holds.
- R3: A strobe with mode 0, or with any mode code from 10 to 15, leaves X, Y, Z and L unchanged and clears done_o in the next cycle.
- R4: Mode 1 (post-increment) and mode 2 (post-decrement) change X by +1 or -1 modulo 256 in the cycle after the strobe. In that same cycle done_o is 1 exactly when the new X is zero.
- R5: Modes 3 and 4 step X by +1 or -1. They then exchange the pair with L: L becomes {Z, stepped X}, Z takes L[15:8], X takes L[7:0], and done_o becomes 0.
- R6: Mode 5 loads Y with X+1 (mod 256) and X with the old Y. done_o becomes 0.
- R7: Modes 6 and 7 step X by +1 or -1, leave Y unchanged, and set done_o to 1 exactly when the stepped X equals Y.
- R8: Mode 8 exchanges X and Y. Mode 9 copies {Z, X} into L and leaves X, Y and Z unchanged. Both modes make done_o 0.
- R9: link_addr_o is the 14-bit address held in L: {L[14:8], L[6:0]}. Bits 15 and 7 of L are dropped.
- R10: When ld_en is 1, the next edge writes ld_data into the register chosen by ld_sel (0 X from bits 7:0, 1 Y from bits 7:0, 2 Z from bits 7:0, 3 L from all 16 bits). Any strobe in that cycle is ignored, and done_o keeps its value.
- R11: rst_n low clears X, Y, Z, L and done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_stb | input | 1 | Access strobe, one register update per cycle it is high |
| acc_mode | input | 4 | Update variant for the strobed access |
| ld_en | input | 1 | Direct register load enable |
| ld_sel | input | 2 | Register chosen for the load |
| ld_data | input | 16 | Load value |
| addr_o | output | 14 | Data-memory address from Z and X |
| link_addr_o | output | 14 | Address view of L |
| done_o | output | 1 | Zero-crossing or compare-match flag |
| x_o | output | 8 | Contents of X |
| y_o | output | 8 | Contents of Y |
| z_o | output | 8 | Contents of Z |
| l_o | output | 16 | Contents of L |

## Verification
addr_o and link_addr_o are combinational, so they are due in the same cycle as the register contents that feed them. The bench compares them one half cycle after the last load edge. Register updates and done_o are due exactly one edge after a strobe or load. The bench drives every stimulus on a falling edge and compares on the next falling edge. It sweeps all 256 X values against all 16 mode codes, with Y chosen to land on, just miss and stay far from the stepped X.

// File: rtl/pdag_pkg.sv
package pdag_pkg;
  localparam int DW = 8;          // counter width
  localparam int LW = 2 * DW;     // link width
  localparam int PW = DW - 1;     // page / byte field width
  localparam int AW = 2 * PW;     // address width

  typedef enum logic [3:0] {
    M_BASE  = 4'd0,
    M_INC   = 4'd1,
    M_DEC   = 4'd2,
    M_INC_L = 4'd3,
    M_DEC_L = 4'd4,
    M_INC_Y = 4'd5,
    M_INC_C = 4'd6,
    M_DEC_C = 4'd7,
    M_SWP_Y = 4'd8,
    M_CPY_L = 4'd9
  } mode_e;

  typedef struct packed {
    logic [LW-1:0] l;
    logic [DW-1:0] z;
    logic [DW-1:0] y;
    logic [DW-1:0] x;
  } regs_t;
endpackage

// File: rtl/pdag_addr_form.sv
module pdag_addr_form
  import pdag_pkg::*;
#(
  parameter bit SHORT_EN = 1'b1
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] z_i,
  input  logic [LW-1:0] l_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] link_addr_o
);
  logic [PW-1:0] page;

  generate
    if (SHORT_EN) begin : g_short
      always_comb page = x_i[DW-1] ? z_i[PW-1:0] : '0;
    end else begin : g_long
      always_comb page = z_i[PW-1:0];
    end
  endgenerate

  always_comb begin
    addr_o      = {page, x_i[PW-1:0]};
    link_addr_o = {l_i[LW-2:DW], l_i[PW-1:0]};
  end
endmodule

// File: rtl/pdag_xstep.sv
module pdag_xstep
  import pdag_pkg::*;
(
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          down_i,
  output logic [DW-1:0] x_step_o,
  output logic          zero_o,
  output logic          match_o
);
  always_comb begin
    x_step_o = down_i ? (x_i - 1'b1) : (x_i + 1'b1);
    zero_o   = (x_step_o == '0);
    match_o  = (x_step_o == y_i);
  end
endmodule

// File: rtl/pdag_next.sv
module pdag_next
  import pdag_pkg::*;
(
  input  regs_t         cur_i,
  input  logic [3:0]    mode_i,
  input  logic          ld_en_i,
  input  logic [1:0]    ld_sel_i,
  input  logic [LW-1:0] ld_data_i,
  output regs_t         nxt_o,
  output logic          done_nxt_o
);
  logic          down;
  logic [DW-1:0] x_step;
  logic          zero;
  logic          match;

  always_comb begin
    case (mode_i)
      M_DEC, M_DEC_L, M_DEC_C: down = 1'b1;
      default:                 down = 1'b0;
    endcase
  end

  pdag_xstep u_step (
    .x_i      (cur_i.x),
    .y_i      (cur_i.y),
    .down_i   (down),
    .x_step_o (x_step),
    .zero_o   (zero),
    .match_o  (match)
  );

  always_comb begin
    nxt_o      = cur_i;
    done_nxt_o = 1'b0;
    if (ld_en_i) begin
      case (ld_sel_i)
        2'd0:    nxt_o.x = ld_data_i[DW-1:0];
        2'd1:    nxt_o.y = ld_data_i[DW-1:0];
        2'd2:    nxt_o.z = ld_data_i[DW-1:0];
        default: nxt_o.l = ld_data_i;
      endcase
    end else begin
      case (mode_i)
        M_INC, M_DEC: begin
          nxt_o.x    = x_step;
          done_nxt_o = zero;
        end
        M_INC_L, M_DEC_L: begin
          nxt_o.l = {cur_i.z, x_step};
          nxt_o.z = cur_i.l[LW-1:DW];
          nxt_o.x = cur_i.l[DW-1:0];
        end
        M_INC_Y: begin
          nxt_o.y = x_step;
          nxt_o.x = cur_i.y;
        end
        M_INC_C, M_DEC_C: begin
          nxt_o.x    = x_step;
          done_nxt_o = match;
        end
        M_SWP_Y: begin
          nxt_o.x = cur_i.y;
          nxt_o.y = cur_i.x;
        end
        M_CPY_L: nxt_o.l = {cur_i.z, cur_i.x};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/paged_addr_gen.sv
module paged_addr_gen
  import pdag_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_stb,
  input  logic [3:0]    acc_mode,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [15:0]   ld_data,
  output logic [13:0]   addr_o,
  output logic [13:0]   link_addr_o,
  output logic          done_o,
  output logic [7:0]    x_o,
  output logic [7:0]    y_o,
  output logic [7:0]    z_o,
  output logic [15:0]   l_o
);
  regs_t cur_q;
  regs_t nxt;
  logic  done_q;
  logic  done_nxt;
  logic  reg_en;
  logic  done_en;

  pdag_next u_next (
    .cur_i      (cur_q),
    .mode_i     (acc_mode),
    .ld_en_i    (ld_en),
    .ld_sel_i   (ld_sel),
    .ld_data_i  (ld_data),
    .nxt_o      (nxt),
    .done_nxt_o (done_nxt)
  );

  always_comb begin
    reg_en  = acc_stb | ld_en;
    done_en = acc_stb & ~ld_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (reg_en) cur_q <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= 1'b0;
    else if (done_en) done_q <= done_nxt;
  end

  pdag_addr_form #(.SHORT_EN(1'b1)) u_addr (
    .x_i         (cur_q.x),
    .z_i         (cur_q.z),
    .l_i         (cur_q.l),
    .addr_o      (addr_o),
    .link_addr_o (link_addr_o)
  );

  always_comb begin
    x_o    = cur_q.x;
    y_o    = cur_q.y;
    z_o    = cur_q.z;
    l_o    = cur_q.l;
    done_o = done_q;
  end
endmodule

// File: rtl/pdag_checker.sv
module pdag_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_stb,
  input logic [3:0]  acc_mode,
  input logic        ld_en,
  input logic [1:0]  ld_sel,
  input logic [15:0] ld_data,
  input logic [13:0] addr_o,
  input logic        done_o,
  input logic [7:0]  x_o,
  input logic [7:0]  y_o,
  input logic [7:0]  z_o,
  input logic [15:0] l_o
);
  logic acc;
  assign acc = acc_stb && !ld_en;

  p_short_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !x_o[7] |-> addr_o[13:7] == 7'd0);

  p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && acc_mode == 4'd0 |=> $stable(x_o) && $stable(y_o) && $stable(z_o) && $stable(l_o) && !done_o);

  p_post_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && acc_mode == 4'd1 |=> x_o == $past(x_o) + 8'd1 && done_o == (x_o == 8'd0));

  p_xy_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && acc_mode == 4'd5 |=> x_o == $past(y_o) && y_o == $past(x_o) + 8'd1);

  p_cmp_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && acc_mode == 4'd7 |=> $stable(y_o) && done_o == (x_o == y_o));

  p_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && acc_mode == 4'd8 |=> x_o == $past(y_o) && y_o == $past(x_o));

  p_load_x_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && ld_sel == 2'd0 |=> x_o == $past(ld_data[7:0]) && $stable(done_o));
endmodule

bind paged_addr_gen pdag_checker u_pdag_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_stb  (acc_stb),
  .acc_mode (acc_mode),
  .ld_en    (ld_en),
  .ld_sel   (ld_sel),
  .ld_data  (ld_data),
  .addr_o   (addr_o),
  .done_o   (done_o),
  .x_o      (x_o),
  .y_o      (y_o),
  .z_o      (z_o),
  .l_o      (l_o)
);

// File: tb/paged_addr_gen_tb.sv
module paged_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_stb = 1'b0;
  logic [3:0]  acc_mode = 4'd0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = 2'd0;
  logic [15:0] ld_data = 16'd0;
  logic [13:0] addr_o;
  logic [13:0] link_addr_o;
  logic        done_o;
  logic [7:0]  x_o, y_o, z_o;
  logic [15:0] l_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  paged_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_mode(acc_mode),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .addr_o(addr_o), .link_addr_o(link_addr_o), .done_o(done_o),
    .x_o(x_o), .y_o(y_o), .z_o(z_o), .l_o(l_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] sel, input logic [15:0] d);
    ld_en = 1'b1; ld_sel = sel; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd1, 4'd2: return "R4";
      4'd3, 4'd4: return "R5";
      4'd5:       return "R6";
      4'd6, 4'd7: return "R7";
      4'd8, 4'd9: return "R8";
      default:    return "R3";
    endcase
  endfunction

  initial begin
    logic [7:0]  ex, ey, ez, xs;
    logic [15:0] el;
    logic        ed;
    logic [7:0]  x, y, z;
    logic [15:0] l;
    string       r;
    repeat (2) @(negedge clk);
    // R11: reset state
    chk("R11 x", x_o, 0); chk("R11 y", y_o, 0); chk("R11 z", z_o, 0);
    chk("R11 l", l_o, 0); chk("R11 done", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int xi = 0; xi < 256; xi++) begin
      for (int mi = 0; mi < 16; mi++) begin
        x = xi[7:0];
        case (xi % 3)
          0: y = x + 8'd1;
          1: y = x - 8'd1;
          default: y = x ^ 8'hA5;
        endcase
        z = ~x ^ mi[7:0];
        l = {x ^ 8'h3C, y ^ 8'hC3} + 16'(mi);
        load(2'd0, {8'h00, x}); load(2'd1, {8'h00, y});
        load(2'd2, {8'h00, z}); load(2'd3, l);
        if (mi == 0) begin
          if (x[7]) chk("R1 addr", addr_o, {z[6:0], x[6:0]});
          else      chk("R2 addr", addr_o, {7'd0, x[6:0]});
          chk("R9 link", link_addr_o, {l[14:8], l[6:0]});
        end
        // expected update
        ex = x; ey = y; ez = z; el = l; ed = 1'b0;
        case (mi)
          1, 6: xs = x + 8'd1;
          2, 7: xs = x - 8'd1;
          3, 5: xs = x + 8'd1;
          4:    xs = x - 8'd1;
          default: xs = x;
        endcase
        case (mi)
          1, 2: begin ex = xs; ed = (xs == 8'd0); end
          3, 4: begin el = {z, xs}; ez = l[15:8]; ex = l[7:0]; end
          5:    begin ey = xs; ex = y; end
          6, 7: begin ex = xs; ed = (xs == y); end
          8:    begin ex = y; ey = x; end
          9:    el = {z, x};
          default: ;
        endcase
        r = req_of(mi[3:0]);
        acc_stb = 1'b1; acc_mode = mi[3:0];
        @(negedge clk);
        acc_stb = 1'b0;
        chk({r, " x"}, x_o, ex); chk({r, " y"}, y_o, ey);
        chk({r, " z"}, z_o, ez); chk({r, " l"}, l_o, el);
        chk({r, " done"}, done_o, ed);
      end
    end

    // R10: load wins over a strobe, done_o held
    load(2'd0, 16'h00FF); load(2'd1, 16'h0000);
    acc_stb = 1'b1; acc_mode = 4'd1;
    @(negedge clk);                      // X -> 00, done -> 1
    chk("R4 wrap done", done_o, 1);
    ld_en = 1'b1; ld_sel = 2'd0; ld_data = 16'hBE42;
    @(negedge clk);
    ld_en = 1'b0; acc_stb = 1'b0;
    chk("R10 load priority x", x_o, 8'h42);
    chk("R10 done held", done_o, 1);

    // R11: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 mid x", x_o, 0); chk("R11 mid l", l_o, 0); chk("R11 mid done", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule